// File: doc/BRIEF.md
# LCD Scan Timer with Byte-Serial Pixel Output

This block produces the raster timing for a small parallel-input LCD that takes every pixel as three back-to-back 8-bit colour bytes on one pixel-byte clock. It drives active-low line and frame sync pulses and a data-enable window placed at a fixed distance after the start of each line. It also pulls 16-bit words from an upstream show-ahead FIFO and splits each word into two consecutive output bytes. The default geometry is a 320 by 240 panel: 1224 byte ticks per line, an active run of 960 ticks that starts 204 ticks after the line sync begins, a 90-tick line sync, and 241 line periods per frame. The first line period of each frame is blanking, and the frame sync covers the first three line periods.

The block runs whenever `en` is high. When `en` rises, the frame-side sequencer starts one clock before the line-side counter, so the frame sync is already low when the first line sync falls. When `en` drops, both counters stop and clear on the next clock and both syncs return high. A sticky flag records any cycle in which a word was needed and the FIFO was empty. Only reset clears it.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `hsync_n` and `vsync_n` are 1, `pix_de`, `fifo_pop` and `underflow` are 0, and `line_idx` and `byte_idx` are 0.
- R2: While running, `byte_idx` advances by one each clock from 0 to H_TOTAL_PIX*BYTES_PER_PIX-1 and then returns to 0. `line_idx` advances when `byte_idx` wraps and returns to 0 after V_BLANK_LINES+V_ACTIVE_LINES lines.
- R3: While the line counter runs, `hsync_n` is 0 exactly when `byte_idx` is below HSYNC_TICKS.
- R4: While running, `vsync_n` is 0 exactly when `line_idx` is below VSYNC_LINES. This includes the single arming cycle.
- R5: The first rising edge that samples `en` high enters an arming cycle. In that cycle `vsync_n` is 0, `hsync_n` is 1 and both counters are 0. The line counter starts at `byte_idx` 0 on the next cycle.
- R6: `pix_de` is 1 exactly when `line_idx` lies in [V_BLANK_LINES, V_BLANK_LINES+V_ACTIVE_LINES-1] and `byte_idx` lies in [DE_START, DE_START+H_ACTIVE_PIX*BYTES_PER_PIX-1]. At all other times `pix_byte` is 0.
- R7: Let the offset be `byte_idx`-DE_START inside the window. At an even offset, `pix_byte` shows bits 15:8 of `fifo_word` and `fifo_pop` equals the inverse of `fifo_empty`. At the next odd offset, `pix_byte` shows bits 7:0 of the word most recently popped. `fifo_pop` is never 1 outside the window or at an odd offset.
- R8: `underflow` becomes 1 on the clock after a cycle with an even in-window offset and `fifo_empty`=1. It then stays 1 until reset.
- R9: A clock edge that samples `en` low sets both syncs to 1, `pix_de` to 0, and `line_idx` and `byte_idx` to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-byte clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| fifo_word | input | 16 | Head word of the upstream show-ahead FIFO |
| fifo_empty | input | 1 | Upstream FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this edge |
| pix_byte | output | 8 | Colour byte to the panel |
| pix_de | output | 1 | Data-valid strobe |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| line_idx | output | clog2(V_BLANK_LINES+V_ACTIVE_LINES) | Current line period |
| byte_idx | output | clog2(H_TOTAL_PIX*BYTES_PER_PIX) | Current tick within the line |
| underflow | output | 1 | Sticky FIFO-starved flag |

## Verification
The bench runs a reduced geometry so that several whole frames fit in the run. It targets the following corner cases, each paired with the failure it would expose:
- Line and frame wrap points: an off-by-one counter shows up as a drifted `byte_idx` or `line_idx`.
- First and last bytes of the data window, and the blanking line: a wrong compare opens `pix_de` one tick early or late, or during blanking.
- Byte ordering inside each word: swapped halves, or a pop taken at odd offsets, break the expected byte stream.
- Arming cycle after `en` rises, and stop behaviour when `en` falls mid-line: a design that starts both counters together loses the one-clock lead of the frame sync. One that stops late leaves a sync low or a counter running.
- FIFO-empty stretch inside the window: `underflow` must latch and stay set, and no pop may be issued while the FIFO is empty.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // ticks occupied by a run of pixels when each pixel is sent as several bytes
  function automatic int pix_to_ticks(input int pixels, input int bytes_per_pix);
    return pixels * bytes_per_pix;
  endfunction

  // last tick index of a window of given length starting at first
  function automatic int window_last(input int first, input int length);
    return first + length - 1;
  endfunction

  // bits needed to count 0..count-1
  function automatic int count_bits(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/lcd_run_seq.sv
module lcd_run_seq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic run_v,
  output logic run_h
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_v <= 1'b0;
      run_h <= 1'b0;
    end else begin
      run_v <= 1'b1;
      run_h <= run_v;
    end
  end

  AST_H_NEEDS_V: assert property (@(posedge clk) disable iff (rst)
    run_h |-> run_v); // R5
  AST_V_LEADS_H: assert property (@(posedge clk) disable iff (rst)
    $rose(run_h) |-> $past(run_v)); // R5
endmodule

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int MODULUS = 8,
  localparam int W = lcd_scan_pkg::count_bits(MODULUS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (step)    cnt <= at_last ? '0 : cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && at_last && !clr) |=> cnt == '0); // R2
endmodule

// File: rtl/lcd_byte_unpack.sv
module lcd_byte_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_window,
  input  logic        even_slot,
  input  logic [15:0] fifo_word,
  input  logic        fifo_empty,
  output logic        fifo_pop,
  output logic [7:0]  pix_byte,
  output logic        starve,
  output logic        underflow
);
  logic       need_word;
  logic [7:0] lo_hold;

  assign need_word = in_window && even_slot;
  assign fifo_pop  = need_word && !fifo_empty;
  assign starve    = need_word && fifo_empty;

  always_comb begin
    if (!in_window)     pix_byte = 8'h00;
    else if (even_slot) pix_byte = fifo_word[15:8];
    else                pix_byte = lo_hold;
  end

  always_ff @(posedge clk) begin
    if (rst)           lo_hold <= 8'h00;
    else if (fifo_pop) lo_hold <= fifo_word[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         underflow <= 1'b0;
    else if (starve) underflow <= 1'b1;
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty); // R7
  AST_STARVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    starve |=> underflow); // R8
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow); // R8
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int BYTES_PER_PIX  = 3,
  parameter int H_ACTIVE_PIX   = 320,
  parameter int H_TOTAL_PIX    = 408,
  parameter int HSYNC_TICKS    = 90,
  parameter int DE_START       = 204,
  parameter int V_BLANK_LINES  = 1,
  parameter int V_ACTIVE_LINES = 240,
  parameter int VSYNC_LINES    = 3,
  localparam int H_TICKS = pix_to_ticks(H_TOTAL_PIX, BYTES_PER_PIX),
  localparam int V_TOTAL = V_BLANK_LINES + V_ACTIVE_LINES,
  localparam int BW      = count_bits(H_TICKS),
  localparam int LW      = count_bits(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [15:0]   fifo_word,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  output logic [7:0]    pix_byte,
  output logic          pix_de,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [LW-1:0] line_idx,
  output logic [BW-1:0] byte_idx,
  output logic          underflow
);
  localparam int ACT_TICKS = pix_to_ticks(H_ACTIVE_PIX, BYTES_PER_PIX);
  localparam logic [BW-1:0] HSW_B   = BW'(HSYNC_TICKS);
  localparam logic [BW-1:0] HST_B   = BW'(DE_START);
  localparam logic [BW-1:0] HEND_B  = BW'(window_last(DE_START, ACT_TICKS));
  localparam logic [LW-1:0] VSL_B   = LW'(VSYNC_LINES);
  localparam logic [LW-1:0] VST_B   = LW'(V_BLANK_LINES);
  localparam logic [LW-1:0] VEND_B  = LW'(window_last(V_BLANK_LINES, V_ACTIVE_LINES));

  // named internal events
  logic          run_v, run_h;
  logic [BW-1:0] hcnt;
  logic [LW-1:0] vcnt;
  logic          h_last, v_last;
  logic          h_in_win, v_in_win, in_window;
  logic [BW-1:0] win_off;
  logic          even_slot;
  logic          starve;

  lcd_run_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .run_v (run_v),
    .run_h (run_h)
  );

  lcd_axis_counter #(.MODULUS(H_TICKS)) u_hcnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (!en || !run_h),
    .step    (1'b1),
    .cnt     (hcnt),
    .at_last (h_last)
  );

  lcd_axis_counter #(.MODULUS(V_TOTAL)) u_vcnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (!en || !run_v),
    .step    (run_h && h_last),
    .cnt     (vcnt),
    .at_last (v_last)
  );

  assign h_in_win  = (hcnt >= HST_B) && (hcnt <= HEND_B);
  assign v_in_win  = (vcnt >= VST_B) && (vcnt <= VEND_B);
  assign in_window = run_h && h_in_win && v_in_win;
  assign win_off   = hcnt - HST_B;
  assign even_slot = !win_off[0];

  lcd_byte_unpack u_unpack (
    .clk        (clk),
    .rst        (rst),
    .in_window  (in_window),
    .even_slot  (even_slot),
    .fifo_word  (fifo_word),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .pix_byte   (pix_byte),
    .starve     (starve),
    .underflow  (underflow)
  );

  assign pix_de   = in_window;
  assign hsync_n  = !(run_h && (hcnt < HSW_B));
  assign vsync_n  = !(run_v && (vcnt < VSL_B));
  assign line_idx = vcnt;
  assign byte_idx = hcnt;

  AST_HS_EARLY: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (byte_idx < HSW_B)); // R3
  AST_VS_EARLY: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> (line_idx < VSL_B)); // R4
  AST_POP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> pix_de); // R7
  AST_DE_NOT_BLANK: assert property (@(posedge clk) disable iff (rst)
    pix_de |-> (line_idx >= VST_B)); // R6
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && run_h && h_last && v_last) |=> (line_idx == '0)); // R2
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hsync_n && vsync_n && !pix_de && byte_idx == '0 && line_idx == '0)); // R9
endmodule

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BPP = 3, HAP = 4, HTP = 10, HSW = 5, HST = 8;
  localparam int VBL = 1, VACT = 4, VSL = 3;
  localparam int HT  = HTP * BPP;
  localparam int VT  = VBL + VACT;
  localparam int ACT = HAP * BPP;

  typedef struct {
    int    hs, vs, de, pop, uf, line, bidx, data;
    string ctx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        fifo_empty = 1'b0;
  logic [15:0] fifo_word;
  logic        fifo_pop, pix_de, hsync_n, vsync_n, underflow;
  logic [7:0]  pix_byte;
  logic [2:0]  line_idx;
  logic [4:0]  byte_idx;

  int vectors = 0, miscompares = 0;
  bit summary_done = 0;
  exp_t sb[$];

  // bench FIFO: word k has a recognisable pattern
  int wi = 0;
  function automatic logic [15:0] wordf(input int k);
    return {8'(k) ^ 8'hA5, 8'(k + 60)};
  endfunction
  assign fifo_word = wordf(wi);
  always @(posedge clk) begin
    if (rst) wi <= 0;
    else if (fifo_pop) wi <= wi + 1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_timer #(
    .BYTES_PER_PIX(BPP), .H_ACTIVE_PIX(HAP), .H_TOTAL_PIX(HTP),
    .HSYNC_TICKS(HSW), .DE_START(HST), .V_BLANK_LINES(VBL),
    .V_ACTIVE_LINES(VACT), .VSYNC_LINES(VSL)
  ) u_dut (
    .clk(clk), .rst(rst), .en(en), .fifo_word(fifo_word),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .pix_byte(pix_byte),
    .pix_de(pix_de), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .line_idx(line_idx), .byte_idx(byte_idx), .underflow(underflow)
  );

  // reference model state
  bit running = 0;
  int t = 0, ewi = 0, elo = 0, euf = 0;
  int prev_pop = 0, prev_starve = 0;

  task automatic step(input bit new_rst, input bit new_en, input bit new_empty);
    exp_t e;
    int u, off;
    @(posedge clk);
    #1;
    // advance model with inputs seen at this edge
    if (rst) begin
      running = 0; t = 0; ewi = 0; elo = 0; euf = 0;
    end else begin
      if (prev_starve != 0) euf = 1;
      if (prev_pop != 0) begin
        elo = int'(wordf(ewi)[7:0]);
        ewi++;
      end
      if (!en) running = 0;
      else if (!running) begin running = 1; t = 0; end
      else t++;
    end
    rst = new_rst; en = new_en; fifo_empty = new_empty;
    e.hs = 1; e.vs = 1; e.de = 0; e.pop = 0; e.line = 0; e.bidx = 0; e.data = 0;
    e.uf = euf; e.ctx = "";
    prev_pop = 0; prev_starve = 0;
    if (!running) e.ctx = (euf == 0 && ewi == 0) ? "R1" : "R9";
    else if (t == 0) begin
      e.vs = 0; e.ctx = "R5";
    end else begin
      u = t - 1;
      e.bidx = u % HT;
      e.line = (u / HT) % VT;
      e.hs = (e.bidx < HSW) ? 0 : 1;
      e.vs = (e.line < VSL) ? 0 : 1;
      if (e.line >= VBL && e.line < VBL + VACT && e.bidx >= HST && e.bidx < HST + ACT) begin
        e.de = 1;
        off = e.bidx - HST;
        if (off % 2 == 0) begin
          e.data = int'(wordf(ewi)[15:8]);
          if (fifo_empty) prev_starve = 1;
          else begin e.pop = 1; prev_pop = 1; end
        end else e.data = elo;
      end
    end
    sb.push_back(e);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic string pick(input string ctx, input string own);
    return (ctx != "") ? ctx : own;
  endfunction

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(pick(e.ctx, "R3"), "hsync_n",   int'(hsync_n),   e.hs);
      chk(pick(e.ctx, "R4"), "vsync_n",   int'(vsync_n),   e.vs);
      chk(pick(e.ctx, "R6"), "pix_de",    int'(pix_de),    e.de);
      chk(pick(e.ctx, "R7"), "fifo_pop",  int'(fifo_pop),  e.pop);
      chk(pick(e.ctx, "R7"), "pix_byte",  int'(pix_byte),  e.data);
      chk(pick(e.ctx, "R8"), "underflow", int'(underflow), e.uf);
      chk(pick(e.ctx, "R2"), "line_idx",  int'(line_idx),  e.line);
      chk(pick(e.ctx, "R2"), "byte_idx",  int'(byte_idx),  e.bidx);
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset held, then idle
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    // R5 arming, then R2/R3/R4/R6/R7 over two full frames
    for (int i = 0; i < 2 * HT * VT + 20; i++) step(1'b0, 1'b1, 1'b0);
    // R9: drop enable mid-line
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0);
    // R5: restart, run into the active lines
    for (int i = 0; i < HT * 2 + 4; i++) step(1'b0, 1'b1, 1'b0);
    // R8: starve the FIFO across the data window, then refill
    for (int i = 0; i < HT; i++) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < HT * VT; i++) step(1'b0, 1'b1, 1'b0);
    // R8: flag survives a disable; R1 clears it
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule